// File: doc/BRIEF.md
# Oversampled Serial Receiver

This block turns an asynchronous serial line back into bytes. It watches the line on a clock-enable strobe that runs at sixteen times the bit rate. A high-to-low transition on the idle line is taken as a possible start bit. The block confirms the start bit near its middle, then samples every following bit near its centre. It collects 5 to 8 data bits, least significant bit first, then an optional parity bit, then one stop bit.

A finished character is placed in a holding register, and the block reports five status indications: data ready, overrun, parity error, framing error and break. The host takes the character with a data-read strobe, which clears data ready. A status-read strobe clears the four error indications. The frame format (word length and parity mode) comes from inputs that the host holds steady while a character is arriving.

Top module: `serial_rx_oversampled`

## Requirements
- R1: After reset, `rx_data` is 00 and `data_ready`, `overrun`, `parity_err`, `framing_err` and `break_flag` are all 0.
- R2: A frame begins on a tick where the line was 1 on the previous tick and is 0 now. The line is sampled again on the 7th tick after that one. If the line is 1 at that sample, the event is a false start: nothing is loaded, and the receiver waits for the next falling edge.
- R3: Data bits are sampled every 16 ticks after the start sample, least significant bit first. There are 5 + `word_len` data bits (`word_len` 0 gives 5 bits, 3 gives 8 bits). The unused upper bits of `rx_data` read 0.
- R4: With `par_en`=1, one parity bit follows the data. The expected value is set as follows. With `par_force`=0 and `par_even`=1, the parity bit makes the total number of ones even. With `par_force`=0 and `par_even`=0, it makes the total odd. With `par_force`=1, the expected bit is the inverse of `par_even`. When the received bit differs from the expected value, `parity_err` is set as the character loads.
- R5: The stop bit is sampled 16 ticks after the last data or parity sample. If it is 0, `framing_err` is set as the character loads.
- R6: If every data, parity and stop sample is 0, the character is a break. `break_flag` and `framing_err` are both set, and `rx_data` loads 00.
- R7: `data_ready` rises in the clock cycle after the stop sample, and `rx_data` shows the new character from that cycle. A `rd_data` strobe clears `data_ready` in the next cycle. If `rd_data` falls in the same cycle as a stop sample, the new character loads and `data_ready` stays 1.
- R8: If a stop sample occurs while `data_ready` is 1 and `rd_data` is 0, `overrun` is set. The new character is discarded, so `rx_data`, `parity_err`, `framing_err` and `break_flag` keep their values.
- R9: A `rd_status` strobe clears `overrun`, `parity_err`, `framing_err` and `break_flag` in the next cycle. A flag that a stop sample sets in that same cycle is 1 afterwards.
- R10: The four error flags stay set until a `rd_status` strobe. `rd_data` does not clear them.
- R11: After a stop sample, a new frame can only begin after the line has been seen at 1 on a tick. A line held low after a break therefore loads no second character.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | Enable at 16 times the bit rate |
| rxd | input | 1 | Serial line, idle high |
| word_len | input | 2 | Data bits minus 5 |
| par_en | input | 1 | Parity bit present |
| par_even | input | 1 | Even parity select, or inverse of the forced value |
| par_force | input | 1 | Forced parity select |
| rd_data | input | 1 | Host reads the holding register |
| rd_status | input | 1 | Host reads the status flags |
| rx_data | output | MAX_BITS | Holding register |
| data_ready | output | 1 | Character waiting |
| overrun | output | 1 | Character lost, holding register was full |
| parity_err | output | 1 | Parity mismatch |
| framing_err | output | 1 | Stop bit sampled 0 |
| break_flag | output | 1 | Break received |

## Verification
Completion of a character can land in the same cycle as a host read. That read can clear data ready, clear the status flags, or do both. The bench provokes this by asserting `rd_data` and `rd_status` on exactly the tick of the stop sample, with a bad stop bit, while an older character and an overrun are still pending. It then expects the new byte to be loaded, `data_ready` to stay high, the new framing error to survive, and the older overrun to be cleared. A behavioural model checks the outputs on every clock against these rules and also checks the cycle that follows.

// File: rtl/serial_rx_oversampled.sv
module serial_rx_oversampled #(
  parameter int OVERSAMPLE = 16,
  parameter int MAX_BITS   = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                tick,
  input  logic                rxd,
  input  logic [1:0]          word_len,
  input  logic                par_en,
  input  logic                par_even,
  input  logic                par_force,
  input  logic                rd_data,
  input  logic                rd_status,
  output logic [MAX_BITS-1:0] rx_data,
  output logic                data_ready,
  output logic                overrun,
  output logic                parity_err,
  output logic                framing_err,
  output logic                break_flag
);
  localparam int CW   = $clog2(OVERSAMPLE);
  localparam int IW   = $clog2(MAX_BITS);
  localparam int MID  = OVERSAMPLE / 2 - 2;
  localparam int LAST = OVERSAMPLE - 1;

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP} rx_state_t;

  rx_state_t           state;
  logic [CW-1:0]       cnt;
  logic [IW-1:0]       idx;
  logic [MAX_BITS-1:0] shreg;
  logic                par_bit;
  logic                line_q;

  logic [IW-1:0] last_idx;
  logic          at_mid, at_end, fin, exp_par, perr, ferr, brk, load, drop;

  assign last_idx = IW'(32'(word_len) + 4);
  assign at_mid   = cnt == CW'(MID);
  assign at_end   = cnt == CW'(LAST);
  assign fin      = tick && state == S_STOP && at_end;
  assign exp_par  = par_force ? ~par_even : (par_even ? ^shreg : ~^shreg);
  assign perr     = par_en && (par_bit != exp_par);
  assign ferr     = !rxd;
  assign brk      = !rxd && shreg == '0 && !(par_en && par_bit);
  assign load     = fin && (!data_ready || rd_data);
  assign drop     = fin && data_ready && !rd_data;

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= S_IDLE;
      cnt     <= '0;
      idx     <= '0;
      shreg   <= '0;
      par_bit <= 1'b0;
      line_q  <= 1'b1;
    end else if (tick) begin
      line_q <= rxd;
      cnt    <= cnt + CW'(1);
      case (state)
        S_IDLE: begin
          cnt <= '0;
          if (line_q && !rxd) state <= S_START;
        end
        S_START: begin
          if (at_mid) begin
            cnt   <= '0;
            idx   <= '0;
            shreg <= '0;
            state <= rxd ? S_IDLE : S_DATA;
          end
        end
        S_DATA: begin
          if (at_end) begin
            shreg[idx] <= rxd;
            cnt        <= '0;
            if (idx == last_idx) state <= par_en ? S_PAR : S_STOP;
            else                 idx   <= idx + IW'(1);
          end
        end
        S_PAR: begin
          if (at_end) begin
            par_bit <= rxd;
            cnt     <= '0;
            state   <= S_STOP;
          end
        end
        S_STOP: begin
          if (at_end) begin
            cnt   <= '0;
            state <= S_IDLE;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_data     <= '0;
      data_ready  <= 1'b0;
      overrun     <= 1'b0;
      parity_err  <= 1'b0;
      framing_err <= 1'b0;
      break_flag  <= 1'b0;
    end else begin
      if (load) rx_data <= shreg;
      data_ready  <= load | (data_ready & ~rd_data);
      overrun     <= drop | (overrun & ~rd_status);
      parity_err  <= (load & perr) | (parity_err & ~rd_status);
      framing_err <= (load & ferr) | (framing_err & ~rd_status);
      break_flag  <= (load & brk) | (break_flag & ~rd_status);
    end
  end
endmodule

// File: rtl/serial_rx_checks.sv
module serial_rx_checks #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         rd_data,
  input logic         rd_status,
  input logic         fin,
  input logic [W-1:0] rx_data,
  input logic         data_ready,
  input logic         overrun,
  input logic         parity_err,
  input logic         framing_err,
  input logic         break_flag
);
  a_r7_ready_clears: assert property (@(posedge clk) disable iff (rst)
    (rd_data && !fin) |=> !data_ready);

  a_r8_holding_kept: assert property (@(posedge clk) disable iff (rst)
    (data_ready && !rd_data) |=> $stable(rx_data));

  a_r6_break_implies_framing: assert property (@(posedge clk) disable iff (rst)
    break_flag |-> framing_err);

  a_r6_break_zero_byte: assert property (@(posedge clk) disable iff (rst)
    $rose(break_flag) |-> rx_data == '0);

  a_r4_parity_on_load: assert property (@(posedge clk) disable iff (rst)
    $rose(parity_err) |-> $past(fin));

  a_r9_status_clears: assert property (@(posedge clk) disable iff (rst)
    (rd_status && !fin) |=> !(overrun || parity_err || framing_err || break_flag));

  a_r10_sticky: assert property (@(posedge clk) disable iff (rst)
    (parity_err && !rd_status) |=> parity_err);
endmodule

bind serial_rx_oversampled serial_rx_checks #(.W(MAX_BITS)) u_checks (
  .clk(clk), .rst(rst), .rd_data(rd_data), .rd_status(rd_status), .fin(fin),
  .rx_data(rx_data), .data_ready(data_ready), .overrun(overrun),
  .parity_err(parity_err), .framing_err(framing_err), .break_flag(break_flag)
);

// File: tb/tb_serial_rx_oversampled.sv
module tb_serial_rx_oversampled;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 0, rst = 1, rxd = 1;
  logic [1:0] word_len = 2'd3;
  logic par_en = 0, par_even = 0, par_force = 0;
  logic rd_data = 0, rd_status = 0;
  logic [7:0] rx_data;
  logic data_ready, overrun, parity_err, framing_err, break_flag;
  logic [1:0] tdiv = 0;
  wire tick = (tdiv == 2'd0);
  int checks = 0, errors = 0, cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) tdiv <= tdiv + 2'd1;

  serial_rx_oversampled dut (
    .clk(clk), .rst(rst), .tick(tick), .rxd(rxd), .word_len(word_len),
    .par_en(par_en), .par_even(par_even), .par_force(par_force),
    .rd_data(rd_data), .rd_status(rd_status), .rx_data(rx_data),
    .data_ready(data_ready), .overrun(overrun), .parity_err(parity_err),
    .framing_err(framing_err), .break_flag(break_flag));

  // behavioural reference
  int m_t = 0;
  bit m_act = 0, m_prev = 1;
  bit m_samp[$];
  logic [7:0] m_rx = 0;
  bit m_dr = 0, m_ovr = 0, m_pe = 0, m_fe = 0, m_bi = 0;

  always @(posedge clk) begin
    bit done, stopb, pbit, expb, perr, brk, ld, dp;
    logic [7:0] d;
    int nb, tot, ones;
    done = 0;
    if (rst) begin
      m_act = 0; m_prev = 1; m_rx = 0;
      m_dr = 0; m_ovr = 0; m_pe = 0; m_fe = 0; m_bi = 0;
    end else begin
      nb = 5 + int'(word_len);
      tot = nb + int'(par_en) + 1;
      if (tick) begin
        if (m_act) begin
          m_t++;
          if (m_t == 7) begin
            if (rxd) m_act = 0;
          end else if (m_t > 7 && (m_t - 7) % 16 == 0) begin
            m_samp.push_back(rxd);
            if (m_samp.size() == tot) begin done = 1; m_act = 0; end
          end
        end else if (m_prev && !rxd) begin
          m_act = 1; m_t = 0; m_samp.delete();
        end
        m_prev = rxd;
      end
      d = 0; ones = 0; pbit = 0; perr = 0; brk = 0; stopb = 1;
      if (done) begin
        for (int i = 0; i < nb; i++) begin d[i] = m_samp[i]; ones += int'(m_samp[i]); end
        stopb = m_samp[tot-1];
        if (par_en) begin
          pbit = m_samp[nb];
          if (par_force) expb = !par_even;
          else expb = par_even ? (ones % 2 == 1) : (ones % 2 == 0);
          perr = (pbit != expb);
        end
        brk = (d == 0) && !pbit && !stopb;
      end
      ld = done && (!m_dr || rd_data);
      dp = done && m_dr && !rd_data;
      if (rd_status) begin m_ovr = 0; m_pe = 0; m_fe = 0; m_bi = 0; end
      if (rd_data) m_dr = 0;
      if (dp) m_ovr = 1;
      if (ld) begin
        m_rx = d; m_dr = 1;
        if (perr) m_pe = 1;
        if (!stopb) m_fe = 1;
        if (brk) m_bi = 1;
      end
    end
  end

  always @(negedge clk) if (!rst) begin
    checks++;
    if (rx_data !== m_rx)     begin errors++; $display("FAIL R3 rx_data actual %h expected %h", rx_data, m_rx); end
    if (data_ready !== m_dr)  begin errors++; $display("FAIL R7 data_ready actual %b expected %b", data_ready, m_dr); end
    if (overrun !== m_ovr)    begin errors++; $display("FAIL R8 overrun actual %b expected %b", overrun, m_ovr); end
    if (parity_err !== m_pe)  begin errors++; $display("FAIL R4 parity_err actual %b expected %b", parity_err, m_pe); end
    if (framing_err !== m_fe) begin errors++; $display("FAIL R5 framing_err actual %b expected %b", framing_err, m_fe); end
    if (break_flag !== m_bi)  begin errors++; $display("FAIL R6 break_flag actual %b expected %b", break_flag, m_bi); end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog actual %0d expected <150000", cyc);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wait_tick();
    do @(negedge clk); while (!tick);
  endtask

  task automatic hold(logic v, int ticks);
    rxd = v;
    repeat (ticks) wait_tick();
  endtask

  task automatic send_frame(logic [7:0] d, bit flip_par, bit stop_v, bit col_rd, bit col_st);
    int nb = 5 + int'(word_len);
    int ones = 0;
    bit p;
    hold(1'b0, 16);
    for (int i = 0; i < nb; i++) begin hold(d[i], 16); ones += int'(d[i]); end
    if (par_en) begin
      if (par_force) p = !par_even;
      else p = par_even ? (ones % 2 == 1) : (ones % 2 == 0);
      hold(p ^ flip_par, 16);
    end
    rxd = stop_v;
    repeat (7) wait_tick();
    rd_data = col_rd; rd_status = col_st;
    @(negedge clk);
    rd_data = 0; rd_status = 0;
    repeat (9) wait_tick();
    hold(1'b1, 16);
  endtask

  task automatic read_data();
    @(negedge clk) rd_data = 1;
    @(negedge clk) rd_data = 0;
  endtask

  task automatic read_status();
    @(negedge clk) rd_status = 1;
    @(negedge clk) rd_status = 0;
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check("R1 rx_data", rx_data, 8'h00);
    check("R1 flags", {3'b0, data_ready, overrun, parity_err, framing_err, break_flag}, 8'h00);
    hold(1'b1, 32);

    word_len = 2'd3; par_en = 0;
    send_frame(8'hA5, 0, 1, 0, 0);
    check("R3 8-bit byte", rx_data, 8'hA5);
    check("R7 ready set", {7'b0, data_ready}, 8'h01);
    read_data();
    check("R7 ready cleared", {7'b0, data_ready}, 8'h00);

    word_len = 2'd0; par_en = 1; par_even = 0; par_force = 0;
    send_frame(8'h13, 0, 1, 0, 0);
    check("R3 5-bit byte", rx_data, 8'h13);
    check("R4 odd parity ok", {7'b0, parity_err}, 8'h00);
    read_data();

    word_len = 2'd2; par_even = 1;
    send_frame(8'h55, 1, 1, 0, 0);
    check("R4 even parity bad", {7'b0, parity_err}, 8'h01);
    check("R3 7-bit byte", rx_data, 8'h55);
    read_data();
    check("R10 flag kept over data read", {7'b0, parity_err}, 8'h01);
    read_status();
    check("R9 status read clears", {7'b0, parity_err}, 8'h00);

    word_len = 2'd1; par_force = 1; par_even = 0;
    send_frame(8'h2A, 0, 1, 0, 0);
    check("R4 forced one ok", {7'b0, parity_err}, 8'h00);
    read_data();
    par_even = 1;
    send_frame(8'h0F, 1, 1, 0, 0);
    check("R4 forced zero bad", {7'b0, parity_err}, 8'h01);
    read_status(); read_data();

    word_len = 2'd3; par_en = 0; par_force = 0;
    send_frame(8'h5A, 0, 0, 0, 0);
    check("R5 framing", {6'b0, framing_err, break_flag}, 8'h02);
    read_status(); read_data();

    par_en = 1; par_even = 1;
    hold(1'b0, 16 * 13);
    hold(1'b1, 32);
    check("R6 break flags", {6'b0, framing_err, break_flag}, 8'h03);
    check("R6 break byte", rx_data, 8'h00);
    check("R11 no second load", {7'b0, overrun}, 8'h00);
    read_status(); read_data();

    par_en = 0;
    hold(1'b0, 4);
    hold(1'b1, 48);
    check("R2 false start", {7'b0, data_ready}, 8'h00);

    send_frame(8'h11, 0, 1, 0, 0);
    send_frame(8'h22, 0, 1, 0, 0);
    check("R8 overrun set", {7'b0, overrun}, 8'h01);
    check("R8 older byte kept", rx_data, 8'h11);

    send_frame(8'h33, 0, 1, 1, 0);
    check("R7 same-cycle read loads", rx_data, 8'h33);
    check("R7 ready stays", {7'b0, data_ready}, 8'h01);

    send_frame(8'h66, 0, 0, 1, 1);
    check("R9 set wins, overrun cleared", {5'b0, overrun, framing_err, data_ready}, 8'h03);
    check("R9 collided byte", rx_data, 8'h66);

    repeat (10) @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule